// File: doc/BRIEF.md
# Command List Stream Processor

This block walks a list of 32-bit command words in memory and turns it into masked register writes. A list is started by a one-cycle start pulse that carries a byte address and a byte length. The block then reads words one at a time over a request/response memory interface. It groups each packet of words into writes on a register-write port, which carries a register index, a data word and a 4-bit byte enable. When the read cursor reaches the end of the list, the block emits a one-cycle completion interrupt.

A packet begins with its first data word and is followed by a header word. The header names the target register, the byte lanes to write, how many more data words follow, and whether the index stays fixed or steps up by one after each write. Every packet starts on an even word offset from the buffer start. A list can also redirect itself. The block keeps private copies of the two buffer-size and two buffer-address registers. A non-zero write to one of the two trigger registers moves execution to the buffer described by those copies. Nothing returns to the old buffer afterwards.

If a header or an extra data word would lie past the buffer end, the block stops there, sets a sticky error flag and still signals completion.

Top module: `cmdlist_engine`

## Requirements
- R1: After a start pulse is taken while idle, the first word of every packet is read before its header, and that first word is written to the index held in the header.
- R2: Header fields: bits [15:0] target index, bits [19:16] lane mask, bits [27:20] count of extra data words, bit 31 index mode. Bits [30:28] are ignored. After the first word, each extra word is written in turn.
- R3: All writes of a packet carry the header's lane mask unchanged on `wr_be_o`. Bit k enables data bits [8k+7:8k], so 4'b1001 selects the top and bottom bytes.
- R4: With header bit 31 set, the write index rises by one after each write. With it clear, every write of the packet goes to the same index.
- R5: Before a packet is fetched, if the count of words consumed since the buffer start is odd, one word is skipped and never written.
- R6: Processing ends when the cursor reaches start + length/4 words. `done_o` is then high for exactly one cycle and `busy_o` falls in the next cycle. A zero-length list produces no writes.
- R7: If a header or an extra word lies at or past the buffer end, no further writes occur, `err_o` rises and stays high, and `done_o` still pulses. The next accepted start clears `err_o`.
- R8: Writes to index 0x238/0x239 (sizes of buffers 0/1) and 0x23A/0x23B (addresses of buffers 0/1) are forwarded on the port. They also update private copies, and only in the enabled byte lanes.
- R9: A write to 0x23C (buffer 0) or 0x23D (buffer 1) whose full 32-bit data is non-zero jumps to byte address (address copy & 0x0FFFFFFF) << 3 with byte length (size copy & 0xFFFFF) << 3. The rest of the current buffer is abandoned.
- R10: A write of zero to a trigger register is forwarded like any other write and does not redirect execution.
- R11: A read request holds its address until `mem_req_ready_i` is high. A register write holds index, data and lanes until `wr_ready_i` is high. Stalls on either side do not change the write sequence.
- R12: A start pulse that arrives while `busy_o` is high is ignored.
- R13: After reset the block is idle, with `busy_o`, `done_o`, `err_o`, `mem_req_valid_o` and `wr_valid_o` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| start_addr_i | input | ADDR_W | Byte address of the list |
| start_size_i | input | SIZE_W | Byte length of the list |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | ADDR_W | Byte address of the requested word |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data |
| wr_valid_o | output | 1 | Register write valid |
| wr_ready_i | input | 1 | Register side accepts the write |
| wr_index_o | output | 16 | Register index |
| wr_data_o | output | 32 | Write data |
| wr_be_o | output | 4 | Byte lane enables |
| busy_o | output | 1 | A list is being processed |
| done_o | output | 1 | One-cycle completion interrupt |
| err_o | output | 1 | Sticky overrun flag |

## Verification
A start pulse taken at one rising edge moves the block into its bound check at the next edge. The first read request goes out one cycle after that. Each word then costs one request cycle plus at least one response cycle. Each write takes at least one cycle on the port. The final bound check is followed one cycle later by `done_o`, and `busy_o` drops the cycle after. These latencies stretch with the handshakes, so the bench logs every accepted write at the clock edge and waits for the completion pulse. It then samples `busy_o`, `err_o`, the write log and the completion count on a falling edge. Results are therefore checked after they have settled rather than at a guessed cycle.

// File: rtl/cls_pkg.sv
package cls_pkg;

  localparam int IDX_W  = 16;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  // Register indices whose meaning the block itself depends on
  localparam logic [IDX_W-1:0] REG_SIZE0 = 16'h0238;
  localparam logic [IDX_W-1:0] REG_ADDR0 = 16'h023A;
  localparam logic [IDX_W-1:0] REG_TRIG0 = 16'h023C;
  localparam logic [IDX_W-1:0] REG_TRIG1 = 16'h023D;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_ISSUE,
    ST_WAIT,
    ST_WRITE,
    ST_FINISH
  } state_t;

  typedef enum logic [1:0] {
    K_PARAM,
    K_HEADER,
    K_EXTRA
  } kind_t;

  typedef struct packed {
    logic             incr;
    logic [7:0]       extra;
    logic [LANES-1:0] lanes;
    logic [IDX_W-1:0] idx;
  } hdr_t;

  function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] lanes);
    logic [DATA_W-1:0] m;
    for (int b = 0; b < LANES; b++) m[8*b +: 8] = {8{lanes[b]}};
    return m;
  endfunction

endpackage

// File: rtl/cls_hdr_decode.sv
module cls_hdr_decode
  import cls_pkg::*;
(
  input  logic [DATA_W-1:0] word_i,
  output hdr_t              hdr_o
);
  logic unused_hdr_bits;

  always_comb begin
    hdr_o.idx   = word_i[15:0];
    hdr_o.lanes = word_i[19:16];
    hdr_o.extra = word_i[27:20];
    hdr_o.incr  = word_i[31];
  end

  assign unused_hdr_bits = ^word_i[30:28];
endmodule

// File: rtl/cls_cursor.sv
module cls_cursor #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_base_i,
  input  logic [WORD_W-1:0] load_words_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              at_end_o,
  output logic              odd_o
);
  logic [ADDR_W-1:0] base_q, base_d;
  logic [WORD_W-1:0] ptr_q, ptr_d;
  logic [WORD_W-1:0] end_q, end_d;
  logic              en;

  always_comb begin
    base_d = base_q;
    ptr_d  = ptr_q;
    end_d  = end_q;
    en     = load_i | step_i;
    if (load_i) begin
      base_d = load_base_i;
      ptr_d  = '0;
      end_d  = load_words_i;
    end else if (step_i) begin
      ptr_d = ptr_q + WORD_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ptr_q  <= '0;
      end_q  <= '0;
    end else if (en) begin
      base_q <= base_d;
      ptr_q  <= ptr_d;
      end_q  <= end_d;
    end
  end

  assign addr_o   = base_q + (ADDR_W'(ptr_q) << 2);
  assign at_end_o = (ptr_q >= end_q);
  assign odd_o    = ptr_q[0];
endmodule

// File: rtl/cls_jump_regs.sv
module cls_jump_regs
  import cls_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LANES-1:0]  lanes_i,
  output logic              jump_o,
  output logic [ADDR_W-1:0] jump_base_o,
  output logic [WORD_W-1:0] jump_words_o
);
  localparam int NBUF = 2;

  logic [DATA_W-1:0] size_q [NBUF];
  logic [DATA_W-1:0] addr_q [NBUF];
  logic [DATA_W-1:0] mask;
  logic              sel;
  logic              unused_shadow;

  assign mask = lane_mask(lanes_i);

  for (genvar n = 0; n < NBUF; n++) begin : g_buf
    logic size_en, addr_en;
    assign size_en = fire_i && (idx_i == REG_SIZE0 + IDX_W'(n));
    assign addr_en = fire_i && (idx_i == REG_ADDR0 + IDX_W'(n));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) size_q[n] <= '0;
      else if (size_en) size_q[n] <= (size_q[n] & ~mask) | (data_i & mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) addr_q[n] <= '0;
      else if (addr_en) addr_q[n] <= (addr_q[n] & ~mask) | (data_i & mask);
    end
  end

  assign sel          = (idx_i == REG_TRIG1);
  assign jump_o       = fire_i && ((idx_i == REG_TRIG0) || (idx_i == REG_TRIG1)) && (data_i != '0);
  assign jump_base_o  = ADDR_W'({addr_q[sel][27:0], 3'b000});
  assign jump_words_o = WORD_W'({size_q[sel][19:0], 1'b0});

  assign unused_shadow = ^{addr_q[0][31:28], addr_q[1][31:28], size_q[0][31:20], size_q[1][31:20]};
endmodule

// File: rtl/cmdlist_engine.sv
module cmdlist_engine
  import cls_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 24,
  parameter int WORD_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [SIZE_W-1:0] start_size_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [31:0]       mem_rsp_data_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [15:0]       wr_index_o,
  output logic [31:0]       wr_data_o,
  output logic [3:0]        wr_be_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  state_t            state_q, state_d;
  kind_t             kind_q, kind_d;
  hdr_t              hdr_q, hdr_d, hdr_dec;
  logic [DATA_W-1:0] param_q, param_d;
  logic              err_q, err_d;
  logic              ctx_en;

  logic              cur_load, cur_step, cur_end, cur_odd;
  logic [ADDR_W-1:0] cur_base, cur_addr;
  logic [WORD_W-1:0] cur_words;
  logic              wr_fire, jump;
  logic [ADDR_W-1:0] jump_base;
  logic [WORD_W-1:0] jump_words;

  cls_hdr_decode u_dec (
    .word_i (mem_rsp_data_i),
    .hdr_o  (hdr_dec)
  );

  cls_cursor #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_cur (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .load_i       (cur_load),
    .load_base_i  (cur_base),
    .load_words_i (cur_words),
    .step_i       (cur_step),
    .addr_o       (cur_addr),
    .at_end_o     (cur_end),
    .odd_o        (cur_odd)
  );

  cls_jump_regs #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_jmp (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .fire_i       (wr_fire),
    .idx_i        (hdr_q.idx),
    .data_i       (param_q),
    .lanes_i      (hdr_q.lanes),
    .jump_o       (jump),
    .jump_base_o  (jump_base),
    .jump_words_o (jump_words)
  );

  assign wr_fire = wr_valid_o && wr_ready_i;

  always_comb begin
    state_d         = state_q;
    kind_d          = kind_q;
    hdr_d           = hdr_q;
    param_d         = param_q;
    err_d           = err_q;
    cur_load        = 1'b0;
    cur_step        = 1'b0;
    cur_base        = jump_base;
    cur_words       = jump_words;
    mem_req_valid_o = 1'b0;
    wr_valid_o      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          cur_load  = 1'b1;
          cur_base  = start_addr_i;
          cur_words = WORD_W'(start_size_i >> 2);
          err_d     = 1'b0;
          state_d   = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (cur_end) begin
          state_d = ST_FINISH;
        end else if (cur_odd) begin
          cur_step = 1'b1;
        end else begin
          kind_d  = K_PARAM;
          state_d = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (kind_q != K_PARAM && cur_end) begin
          err_d   = 1'b1;
          state_d = ST_FINISH;
        end else begin
          mem_req_valid_o = 1'b1;
          if (mem_req_ready_i) state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (mem_rsp_valid_i) begin
          cur_step = 1'b1;
          unique case (kind_q)
            K_PARAM: begin
              param_d = mem_rsp_data_i;
              kind_d  = K_HEADER;
              state_d = ST_ISSUE;
            end
            K_HEADER: begin
              hdr_d   = hdr_dec;
              state_d = ST_WRITE;
            end
            default: begin
              param_d = mem_rsp_data_i;
              state_d = ST_WRITE;
            end
          endcase
        end
      end
      ST_WRITE: begin
        wr_valid_o = 1'b1;
        if (wr_ready_i) begin
          if (jump) begin
            cur_load = 1'b1;
            state_d  = ST_CHECK;
          end else if (hdr_q.extra == 8'd0) begin
            state_d = ST_CHECK;
          end else begin
            hdr_d.extra = hdr_q.extra - 8'd1;
            hdr_d.idx   = hdr_q.idx + IDX_W'(hdr_q.incr);
            kind_d      = K_EXTRA;
            state_d     = ST_ISSUE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign ctx_en = (state_q != ST_IDLE) || start_i;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ctx_en) err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      kind_q  <= K_PARAM;
      hdr_q   <= '0;
      param_q <= '0;
    end else if (ctx_en) begin
      kind_q  <= kind_d;
      hdr_q   <= hdr_d;
      param_q <= param_d;
    end
  end

  assign mem_req_addr_o = cur_addr;
  assign wr_index_o     = hdr_q.idx;
  assign wr_data_o      = param_q;
  assign wr_be_o        = hdr_q.lanes;
  assign busy_o         = (state_q != ST_IDLE);
  assign done_o         = (state_q == ST_FINISH);
  assign err_o          = err_q;
endmodule

// File: rtl/cmdlist_engine_checker.sv
module cmdlist_engine_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic [ADDR_W-1:0] mem_req_addr_o,
  input logic              wr_valid_o,
  input logic              wr_ready_i,
  input logic [15:0]       wr_index_o,
  input logic [31:0]       wr_data_o,
  input logic [3:0]        wr_be_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o
);
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  assert_wr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_index_o) && $stable(wr_data_o) && $stable(wr_be_o));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o && !(start_i && !busy_o) |=> err_o);

  assert_err_only_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> done_o);

  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_valid_o && !wr_valid_o && !done_o);

  assert_single_side_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req_valid_o, wr_valid_o, done_o}));
endmodule

bind cmdlist_engine cmdlist_engine_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .start_i         (start_i),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o),
  .wr_valid_o      (wr_valid_o),
  .wr_ready_i      (wr_ready_i),
  .wr_index_o      (wr_index_o),
  .wr_data_o       (wr_data_o),
  .wr_be_o         (wr_be_o),
  .busy_o          (busy_o),
  .done_o          (done_o),
  .err_o           (err_o)
);

// File: tb/cmdlist_engine_test.sv
`timescale 1ns/1ps
module cmdlist_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic [23:0] start_size = '0;
  logic        req_valid, req_ready;
  logic [31:0] req_addr;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        wr_valid, wr_ready;
  logic [15:0] wr_index;
  logic [31:0] wr_data;
  logic [3:0]  wr_be;
  logic        busy, done, err;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  int done_cnt = 0;
  int bad_addr = 0;
  bit stall = 0;

  logic [31:0] mem [256];
  logic [15:0] log_idx [32];
  logic [31:0] log_data [32];
  logic [3:0]  log_be [32];
  int          log_n = 0;
  logic [15:0] exp_idx [32];
  logic [31:0] exp_data [32];
  logic [3:0]  exp_be [32];
  int          exp_n = 0;

  cmdlist_engine uut (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start),
    .start_addr_i    (start_addr),
    .start_size_i    (start_size),
    .mem_req_valid_o (req_valid),
    .mem_req_ready_i (req_ready),
    .mem_req_addr_o  (req_addr),
    .mem_rsp_valid_i (rsp_valid),
    .mem_rsp_data_i  (rsp_data),
    .wr_valid_o      (wr_valid),
    .wr_ready_i      (wr_ready),
    .wr_index_o      (wr_index),
    .wr_data_o       (wr_data),
    .wr_be_o         (wr_be),
    .busy_o          (busy),
    .done_o          (done),
    .err_o           (err)
  );

  always #4 clk = ~clk;

  // Memory model: one-cycle read latency, out-of-range requests counted
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid && req_ready;
      rsp_data  <= mem[req_addr[9:2]];
      if (req_valid && req_ready && req_addr >= 32'd1024) bad_addr <= bad_addr + 1;
      if (wr_valid && wr_ready && log_n < 32) begin
        log_idx[log_n]  <= wr_index;
        log_data[log_n] <= wr_data;
        log_be[log_n]   <= wr_be;
        log_n           <= log_n + 1;
      end
      if (done) done_cnt <= done_cnt + 1;
    end
  end

  always @(negedge clk) begin
    req_ready = stall ? cyc[0] : 1'b1;
    wr_ready  = stall ? (cyc % 3 == 0) : 1'b1;
  end

  function automatic logic [31:0] hdr(input logic [15:0] idx, input logic [3:0] lanes,
                                      input logic [7:0] cnt, input logic inc);
    return {inc, 3'b000, cnt, lanes, idx};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_wr(input logic [15:0] idx, input logic [31:0] data, input logic [3:0] be);
    exp_idx[exp_n]  = idx;
    exp_data[exp_n] = data;
    exp_be[exp_n]   = be;
    exp_n++;
  endtask

  task automatic clear_logs();
    @(negedge clk);
    log_n    = 0;
    exp_n    = 0;
    done_cnt = 0;
  endtask

  task automatic compare_log(input string req);
    check({req, " write count"}, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      check({req, " index"}, {16'h0, log_idx[i]}, {16'h0, exp_idx[i]});
      check({req, " data"}, log_data[i], exp_data[i]);
      check({req, " lanes"}, {28'h0, log_be[i]}, {28'h0, exp_be[i]});
    end
  endtask

  task automatic pulse_start(input logic [31:0] a, input logic [23:0] s);
    @(negedge clk);
    start      = 1'b1;
    start_addr = a;
    start_size = s;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic test_reset();
    check("R13 busy", busy, 0);
    check("R13 done", done, 0);
    check("R13 err", err, 0);
    check("R13 req_valid", req_valid, 0);
    check("R13 wr_valid", wr_valid, 0);
  endtask

  task automatic test_fixed();
    clear_logs();
    expect_wr(16'h41, 32'hAABBCCDD, 4'hF);
    expect_wr(16'h41, 32'h1, 4'hF);
    expect_wr(16'h41, 32'h2, 4'hF);
    pulse_start(32'd64, 24'd16);
    wait_done();
    compare_log("R1 R2 R4 fixed");
    check("R6 done once", done_cnt, 1);
    check("R6 busy low", busy, 0);
  endtask

  task automatic test_empty();
    clear_logs();
    pulse_start(32'd64, 24'd0);
    wait_done();
    check("R6 empty writes", log_n, 0);
    check("R6 empty done", done_cnt, 1);
  endtask

  task automatic test_incr_pad(input string tag);
    clear_logs();
    expect_wr(16'h10, 32'hCAFE0001, 4'h9);
    expect_wr(16'h11, 32'h12345678, 4'h9);
    expect_wr(16'h20, 32'h0000BEEF, 4'h3);
    pulse_start(32'd96, 24'd24);
    wait_done();
    compare_log(tag);
    check({tag, " done"}, done_cnt, 1);
  endtask

  task automatic test_stall_and_restart();
    stall = 1;
    clear_logs();
    expect_wr(16'h10, 32'hCAFE0001, 4'h9);
    expect_wr(16'h11, 32'h12345678, 4'h9);
    expect_wr(16'h20, 32'h0000BEEF, 4'h3);
    pulse_start(32'd96, 24'd24);
    repeat (3) @(negedge clk);
    pulse_start(32'd64, 24'd16); // R12: ignored, busy
    wait_done();
    compare_log("R11 R12 stalled");
    check("R12 single done", done_cnt, 1);
    stall = 0;
  endtask

  task automatic test_overrun();
    clear_logs();
    expect_wr(16'h30, 32'h77, 4'hF);
    expect_wr(16'h31, 32'h88, 4'hF);
    pulse_start(32'd160, 24'd12);
    wait_done();
    compare_log("R7 overrun");
    check("R7 err set", err, 1);
    check("R7 done", done_cnt, 1);
    repeat (4) @(negedge clk);
    check("R7 err sticky", err, 1);
  endtask

  task automatic test_jump0();
    clear_logs();
    expect_wr(16'h238, 32'h1, 4'hF);
    expect_wr(16'h239, 32'h0, 4'hF);
    expect_wr(16'h23A, 32'h20, 4'hF);
    expect_wr(16'h23A, 32'hFFFFFF20, 4'h1);
    expect_wr(16'h23C, 32'h1, 4'hF);
    expect_wr(16'h77, 32'h55, 4'hF);
    pulse_start(32'd192, 24'd40);
    wait_done();
    check("R7 err cleared", err, 0);
    compare_log("R8 R9 jump buffer 0");
    check("R8 masked shadow stays in range", bad_addr, 0);
    check("R9 done once", done_cnt, 1);
  endtask

  task automatic test_jump1();
    clear_logs();
    expect_wr(16'h239, 32'h1, 4'hF);
    expect_wr(16'h23A, 32'h0, 4'hF);
    expect_wr(16'h23B, 32'h20, 4'hF);
    expect_wr(16'h23D, 32'h0, 4'hF);
    expect_wr(16'h50, 32'h11, 4'hF);
    expect_wr(16'h23D, 32'h7, 4'hF);
    expect_wr(16'h77, 32'h55, 4'hF);
    pulse_start(32'd320, 24'd48);
    wait_done();
    compare_log("R9 R10 jump buffer 1");
    check("R10 done once", done_cnt, 1);
    check("R9 no bad address", bad_addr, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    // fixed-index packet at word 16
    mem[16] = 32'hAABBCCDD; mem[17] = hdr(16'h41, 4'hF, 8'd2, 1'b0);
    mem[18] = 32'h1;        mem[19] = 32'h2;
    // incrementing packet, pad word, second packet at word 24
    mem[24] = 32'hCAFE0001; mem[25] = hdr(16'h10, 4'h9, 8'd1, 1'b1);
    mem[26] = 32'h12345678; mem[27] = 32'h80F10055;
    mem[28] = 32'h0000BEEF; mem[29] = hdr(16'h20, 4'h3, 8'd0, 1'b0);
    // overrun list at word 40
    mem[40] = 32'h77; mem[41] = hdr(16'h30, 4'hF, 8'd3, 1'b1); mem[42] = 32'h88;
    // jump through buffer 0 at word 48
    mem[48] = 32'h1;        mem[49] = hdr(16'h238, 4'hF, 8'd2, 1'b1);
    mem[50] = 32'h0;        mem[51] = 32'h20;
    mem[52] = 32'hFFFFFF20; mem[53] = hdr(16'h23A, 4'h1, 8'd0, 1'b0);
    mem[54] = 32'h1;        mem[55] = hdr(16'h23C, 4'hF, 8'd0, 1'b0);
    mem[56] = 32'hDEAD;     mem[57] = hdr(16'h99, 4'hF, 8'd0, 1'b0);
    // jump target at word 64
    mem[64] = 32'h55;       mem[65] = hdr(16'h77, 4'hF, 8'd0, 1'b0);
    // jump through buffer 1 at word 80
    mem[80] = 32'h1;        mem[81] = hdr(16'h239, 4'hF, 8'd2, 1'b1);
    mem[82] = 32'h0;        mem[83] = 32'h20;
    mem[84] = 32'h0;        mem[85] = hdr(16'h23D, 4'hF, 8'd0, 1'b0);
    mem[86] = 32'h11;       mem[87] = hdr(16'h50, 4'hF, 8'd0, 1'b0);
    mem[88] = 32'h7;        mem[89] = hdr(16'h23D, 4'hF, 8'd0, 1'b0);
    mem[90] = 32'hBAD;      mem[91] = hdr(16'h98, 4'hF, 8'd0, 1'b0);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    test_fixed();
    test_empty();
    test_incr_pad("R3 R4 R5 incr pad");
    test_stall_and_restart();
    test_overrun();
    test_jump0();
    test_jump1();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule